// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer Channel

This block is a single timer channel that counts a programmable number of ticks and drives one output pin whose waveform depends on the selected mode. Counting advances only on cycles where the single-cycle tick enable is high, so a system clock plus a divided enable can stand in for a slow timer clock. A register front end supplies a two-bit mode through a mode-write strobe and a 16-bit reload value through a reload-write strobe. The channel presents its live count value so that a separate latch unit can capture it. It also raises a null-count flag while a written reload value is waiting to reach the counting element.

Four modes are supported: a one-shot that raises the pin at terminal count, a rate generator that gives one low tick per period, a square wave, and a software strobe that gives a single low tick after the count expires. In the two periodic modes, a reload written while counting is held back until the current period ends. In the other cases a reload takes effect at once. A mode write stops counting until the next reload arrives.

Top module: `prog_count_chan`

## Requirements
- R1: A reload value of 0 on `rld_i` means a count of 65536. In one-shot mode the pin rises after 65536 ticks. In rate-generator mode the count shows 65535 after one tick.
- R2: In one-shot mode (`mode_i` = 0), the pin is low from the load until N ticks have elapsed. It then goes high and stays high until the next mode or reload write.
- R3: In rate-generator mode (`mode_i` = 1), with e = elapsed ticks mod N, the count is N - e. The pin is low only while e = N-1.
- R4: In square-wave mode (`mode_i` = 2), with e = elapsed ticks mod N, the pin is high while e < ceil(N/2). The count is (N with bit 0 cleared) minus twice the position within the current half.
- R5: In software-strobe mode (`mode_i` = 3), the pin is high except for the single tick interval that follows the N-th tick. No further pulse occurs without a new load.
- R6: After a mode write, counting stops and `null_o` is 1. The pin is low in one-shot mode and high in every other mode. The count stays frozen whatever the tick input does. The same idle levels apply after reset, when the count is 0 and the mode is one-shot.
- R7: In modes 1 and 2, a reload value of 1 is refused. It leaves the count, the period, the pin and `null_o` exactly as they were.
- R8: A reload written while a periodic mode is counting raises `null_o` and does not disturb the running period. The new value takes effect on the tick that ends the current period, and `null_o` clears on that tick.
- R9: In modes 0 and 3, and in any mode while the channel is stopped, an accepted reload restarts counting at once from the new value and leaves `null_o` at 0.
- R10: In modes 0 and 3, the count equals N minus the elapsed ticks, wrapping modulo 65536 after terminal count.
- R11: The count and the pin change only on cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle count enable |
| mode_wr_i | input | 1 | Strobe: take `mode_i` and stop counting |
| mode_i | input | 2 | Mode: 0 one-shot, 1 rate generator, 2 square wave, 3 strobe |
| rld_wr_i | input | 1 | Strobe: take `rld_i` as the new reload value |
| rld_i | input | 16 | Reload value; 0 stands for 65536 |
| out_o | output | 1 | Timer output pin |
| count_o | output | 16 | Live count value for an external latch |
| null_o | output | 1 | A written reload has not yet reached the counter |

## Verification
The bench targets the handover of a reload written during a running periodic count. A design that loads the value at once would show the new count in the middle of a period. One that never clears the pending flag would leave `null_o` stuck high. It also writes a reload of 1 in the periodic modes, both while counting and while stopped; a design that accepts it would clear `null_o` or restart from 1. The zero reload is run to its full 65536-tick terminal count, which catches a design that treats 0 as an immediate expiry. The strobe mode is run well past its pulse so that a repeated or missing low tick shows on the pin. The square wave is run with both odd and even periods, so an error in ceil(N/2) or in clearing bit 0 of the count shows in either the pin or the count.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2,
    MODE_STROBE  = 2'd3
  } cmode_e;

  function automatic logic is_periodic(cmode_e m);
    return (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction

endpackage

// File: rtl/pcc_loader.sv
module pcc_loader
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  cmode_e        mode_in,
  input  logic          rld_wr,
  input  logic [CNT_W-1:0] rld_in,
  input  logic          wrap_evt,
  output cmode_e        mode_q,
  output logic          null_q,
  output logic          run_q,
  output logic          ce_load,
  output logic [NW-1:0] ce_val
);

  logic [NW-1:0] cr_q;
  logic [NW-1:0] n_new;
  logic          refuse, accept, defer, load_imm, load_def;

  function automatic logic [NW-1:0] reload_to_n(logic [CNT_W-1:0] v);
    return (v == '0) ? (NW'(1) << CNT_W) : {1'b0, v};
  endfunction

  always_comb begin
    n_new    = reload_to_n(rld_in);
    refuse   = rld_wr && !mode_wr && is_periodic(mode_q) && (n_new == NW'(1));
    accept   = rld_wr && !mode_wr && !refuse;
    defer    = accept && run_q && is_periodic(mode_q);
    load_imm = accept && !defer;
    load_def = !mode_wr && !accept && null_q && run_q && wrap_evt;
    ce_load  = load_imm || load_def;
    ce_val   = load_imm ? n_new : cr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONESHOT;
      null_q <= 1'b1;
      run_q  <= 1'b0;
      cr_q   <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_in;
      null_q <= 1'b1;
      run_q  <= 1'b0;
    end else if (accept) begin
      cr_q <= n_new;
      if (load_imm) begin
        null_q <= 1'b0;
        run_q  <= 1'b1;
      end else begin
        null_q <= 1'b1;
      end
    end else if (load_def) begin
      null_q <= 1'b0;
    end
  end

  // R6: a mode write leaves the channel stopped with a pending count
  p_mode_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (null_q && !run_q));

  // R7: a refused reload touches neither the stored value nor the flags
  p_refuse_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> ($stable(cr_q) && $stable(null_q) && $stable(run_q)));

  // R8: a deferred reload keeps the channel running with null-count set
  p_defer_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    defer |=> (run_q && null_q));

endmodule

// File: rtl/pcc_core.sv
module pcc_core #(
  parameter int CNT_W = 16,
  localparam int NW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          stop,
  input  logic          periodic,
  input  logic          ce_load,
  input  logic [NW-1:0] ce_val,
  output logic [NW-1:0] ce_q,
  output logic [NW-1:0] elap_q,
  output logic          fired_q,
  output logic          hit_q,
  output logic          wrap_evt
);

  logic          step;
  logic [NW-1:0] elap_nx;
  logic          reach;

  always_comb begin
    step     = tick && run;
    elap_nx  = elap_q + NW'(1);
    reach    = (elap_nx == ce_q);
    wrap_evt = step && periodic && reach;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      elap_q  <= '0;
      fired_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (stop) begin
      elap_q  <= '0;
      fired_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (ce_load) begin
      ce_q    <= ce_val;
      elap_q  <= '0;
      fired_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (step) begin
      if (periodic) begin
        elap_q  <= reach ? '0 : elap_nx;
        fired_q <= 1'b0;
        hit_q   <= 1'b0;
      end else begin
        elap_q  <= elap_nx;
        hit_q   <= reach && !fired_q;
        fired_q <= fired_q || reach;
      end
    end
  end

  // R3: in a periodic mode the elapsed count never reaches the period
  p_period_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && periodic && !stop && !ce_load && ce_q != '0) |=> (elap_q < ce_q));

  // R2: terminal count, once reached, holds until a write
  p_fired_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !stop && !ce_load) |=> fired_q);

  // R5: the strobe pulse lasts a single tick interval
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && step && !stop && !ce_load) |=> !hit_q);

endmodule

// File: rtl/pcc_outdec.sv
module pcc_outdec
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NW = CNT_W + 1
) (
  input  cmode_e           mode,
  input  logic             run,
  input  logic [NW-1:0]    ce,
  input  logic [NW-1:0]    elap,
  input  logic             fired,
  input  logic             hit,
  output logic             out_pin,
  output logic [CNT_W-1:0] count
);

  function automatic logic [NW-1:0] sq_half(logic [NW-1:0] n);
    return NW'(({1'b0, n} + (NW+1)'(1)) >> 1);
  endfunction

  function automatic logic [NW-1:0] sq_count(logic [NW-1:0] n, logic [NW-1:0] e);
    logic [NW-1:0] h, t;
    h = sq_half(n);
    t = (e >= h) ? (e - h) : e;
    return (n & ~NW'(1)) - (t << 1);
  endfunction

  logic [NW-1:0] half;
  logic [NW-1:0] cnt_full;

  always_comb begin
    half = sq_half(ce);
    unique case (mode)
      MODE_SQUARE: cnt_full = sq_count(ce, elap);
      default:     cnt_full = ce - elap;
    endcase
    count = cnt_full[CNT_W-1:0];

    if (!run) begin
      out_pin = (mode != MODE_ONESHOT);
    end else begin
      unique case (mode)
        MODE_ONESHOT: out_pin = fired;
        MODE_RATE:    out_pin = (elap != (ce - NW'(1)));
        MODE_SQUARE:  out_pin = (elap < half);
        default:      out_pin = !hit;
      endcase
    end
  end

endmodule

// File: rtl/prog_count_chan.sv
module prog_count_chan
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             null_o
);

  cmode_e        mode_w;
  logic          null_w, run_w, ce_load_w, wrap_w;
  logic [NW-1:0] ce_val_w, ce_w, elap_w;
  logic          fired_w, hit_w;

  pcc_loader #(.CNT_W(CNT_W)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_wr (mode_wr_i),
    .mode_in (cmode_e'(mode_i)),
    .rld_wr  (rld_wr_i),
    .rld_in  (rld_i),
    .wrap_evt(wrap_w),
    .mode_q  (mode_w),
    .null_q  (null_w),
    .run_q   (run_w),
    .ce_load (ce_load_w),
    .ce_val  (ce_val_w)
  );

  pcc_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .run     (run_w),
    .stop    (mode_wr_i),
    .periodic(is_periodic(mode_w)),
    .ce_load (ce_load_w),
    .ce_val  (ce_val_w),
    .ce_q    (ce_w),
    .elap_q  (elap_w),
    .fired_q (fired_w),
    .hit_q   (hit_w),
    .wrap_evt(wrap_w)
  );

  pcc_outdec #(.CNT_W(CNT_W)) u_outdec (
    .mode   (mode_w),
    .run    (run_w),
    .ce     (ce_w),
    .elap   (elap_w),
    .fired  (fired_w),
    .hit    (hit_w),
    .out_pin(out_o),
    .count  (count_o)
  );

  assign null_o = null_w;

  // R6: a stopped channel holds its count while no write arrives
  p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && !mode_wr_i && !rld_wr_i) |=> $stable(count_o));

  // R11: with no tick and no write, the pin and the count hold
  p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !mode_wr_i && !rld_wr_i) |=> ($stable(count_o) && $stable(out_o)));

endmodule

// File: tb/tb_prog_count_chan.sv
module tb_prog_count_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        mode_wr_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        rld_wr_i = 1'b0;
  logic [15:0] rld_i = 16'd0;
  logic        out_o;
  logic [15:0] count_o;
  logic        null_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prog_count_chan dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .rld_wr_i(rld_wr_i), .rld_i(rld_i),
    .out_o(out_o), .count_o(count_o), .null_o(null_o)
  );

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic wr_mode(int m);
    mode_i = 2'(m); mode_wr_i = 1'b1;
    @(negedge clk); mode_wr_i = 1'b0;
  endtask

  task automatic wr_rld(int v);
    rld_i = 16'(v); rld_wr_i = 1'b1;
    @(negedge clk); rld_wr_i = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R6", "reset out", out_o, 0);
    check("R6", "reset null", null_o, 1);
    check("R6", "reset count", count_o, 0);
    ticks(3);
    check("R6", "reset count after ticks", count_o, 0);
  endtask

  task automatic t_oneshot();
    wr_mode(0); wr_rld(5);
    check("R9", "oneshot null after load", null_o, 0);
    check("R2", "oneshot out at load", out_o, 0);
    check("R10", "oneshot count at load", count_o, 5);
    ticks(3);
    check("R10", "oneshot count e3", count_o, 2);
    check("R2", "oneshot out e3", out_o, 0);
    ticks(1);
    check("R2", "oneshot out e4", out_o, 0);
    repeat (4) @(negedge clk);
    check("R11", "count holds without tick", count_o, 1);
    ticks(1);
    check("R2", "oneshot out e5", out_o, 1);
    check("R10", "oneshot count e5", count_o, 0);
    ticks(2);
    check("R2", "oneshot out stays high", out_o, 1);
    check("R10", "oneshot count wraps", count_o, 16'hFFFE);
  endtask

  task automatic t_rate();
    wr_mode(1);
    check("R6", "rate idle out", out_o, 1);
    check("R6", "rate idle null", null_o, 1);
    wr_rld(4);
    for (int k = 1; k <= 9; k++) begin
      ticks(1);
      check("R3", "rate count", count_o, 4 - (k % 4));
      check("R3", "rate out", out_o, (k % 4 == 3) ? 0 : 1);
    end
  endtask

  task automatic t_square(int n);
    int half;
    half = (n + 1) / 2;
    wr_mode(2); wr_rld(n);
    check("R4", "square count at load", count_o, n - (n % 2));
    for (int k = 1; k <= 2 * n; k++) begin
      ticks(1);
      check("R4", "square out", out_o, ((k % n) < half) ? 1 : 0);
      check("R4", "square count", count_o, (n - (n % 2)) - 2 * ((k % n) % half));
    end
  endtask

  task automatic t_strobe();
    wr_mode(3);
    check("R6", "strobe idle out", out_o, 1);
    wr_rld(3);
    ticks(2);
    check("R5", "strobe out before", out_o, 1);
    ticks(1);
    check("R5", "strobe pulse", out_o, 0);
    check("R10", "strobe count at pulse", count_o, 0);
    ticks(1);
    check("R5", "strobe after pulse", out_o, 1);
    check("R10", "strobe count after", count_o, 16'hFFFF);
    for (int k = 0; k < 6; k++) begin
      ticks(1);
      check("R5", "strobe no repeat", out_o, 1);
    end
  endtask

  task automatic t_refuse();
    wr_mode(1); wr_rld(6);
    ticks(2);
    wr_rld(1);
    check("R7", "refused null", null_o, 0);
    check("R7", "refused count", count_o, 4);
    ticks(4);
    check("R7", "period kept after refuse", count_o, 6);
    wr_mode(2); wr_rld(1);
    check("R7", "refused idle null", null_o, 1);
    check("R7", "refused idle out", out_o, 1);
    ticks(2);
    check("R7", "refused idle count", count_o, 6);
    wr_mode(0); wr_rld(1);
    check("R9", "oneshot accepts 1", null_o, 0);
    ticks(1);
    check("R2", "oneshot N=1 fires", out_o, 1);
  endtask

  task automatic t_defer();
    wr_mode(1); wr_rld(4);
    ticks(1);
    wr_rld(8);
    check("R8", "defer null set", null_o, 1);
    check("R8", "defer count kept", count_o, 3);
    ticks(2);
    check("R8", "old period out low", out_o, 0);
    check("R8", "old period count", count_o, 1);
    check("R8", "null still set", null_o, 1);
    ticks(1);
    check("R8", "null cleared at wrap", null_o, 0);
    check("R8", "new value at wrap", count_o, 8);
    ticks(1);
    check("R8", "new period counting", count_o, 7);
    ticks(7);
    check("R8", "new period length", count_o, 8);
  endtask

  task automatic t_immediate();
    wr_mode(0); wr_rld(10);
    ticks(4);
    check("R10", "oneshot mid count", count_o, 6);
    wr_rld(3);
    check("R9", "immediate count", count_o, 3);
    check("R9", "immediate null", null_o, 0);
    ticks(3);
    check("R9", "immediate out", out_o, 1);
  endtask

  task automatic t_mode_stop();
    wr_mode(1); wr_rld(7);
    ticks(2);
    wr_mode(0);
    check("R6", "stop null", null_o, 1);
    check("R6", "stop out oneshot", out_o, 0);
    check("R6", "stop count", count_o, 7);
    ticks(5);
    check("R6", "stop count frozen", count_o, 7);
    check("R6", "stop out frozen", out_o, 0);
  endtask

  task automatic t_zero();
    wr_mode(1); wr_rld(0);
    ticks(1);
    check("R1", "rate zero reload", count_o, 65535);
    wr_mode(2); wr_rld(0);
    ticks(1);
    check("R1", "square zero reload", count_o, 65534);
    wr_mode(0); wr_rld(0);
    check("R1", "oneshot zero count", count_o, 0);
    ticks(65535);
    check("R1", "zero reload one short", count_o, 1);
    check("R1", "zero reload out low", out_o, 0);
    ticks(1);
    check("R1", "zero reload fires", out_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_rate();
    t_square(5);
    t_square(6);
    t_strobe();
    t_refuse();
    t_defer();
    t_immediate();
    t_mode_stop();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule